// File: doc/BRIEF.md
# ECC-Protected True Dual-Port Word Store

This block is a small single-clock memory of 16 words with two fully independent ports, A and B. Either port can read or write on any cycle. Each port works with 8-bit user data. Before the data reaches storage it is encoded into a 13-bit single-error-correcting, double-error-detecting codeword. On the way out the stored codeword is decoded back to 8 bits, and two status flags report a corrected single-bit error or an uncorrectable double-bit error.

Every path is pipelined. An encoder register, a set of registered array inputs, a registered array read and a decoder register give a fixed four-edge latency from a command to its read result. The ports have no handshake. Each port accepts one command on every clock and produces one result on every clock, so there is no back-pressure: a result appears four edges after its command whether or not anything consumes it. Each port reads the addressed word on every cycle, whether or not it also writes. A debug input lets a test flip chosen bits of a stored codeword directly, to exercise the correction logic.

Top module: `ecc_dpram`

## Requirements
- R1: Data written on either port reads back unchanged on either port, with both flags low. The stored codeword bit i holds Hamming position i. Check bits sit at positions 1, 2, 4 and 8. Data bits 0..7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in ascending order. Bit 0 makes the overall parity of all 13 bits even.
- R2: A command presented before clock edge n yields its read result on the port outputs after edge n+3. A write reaches the array at edge n+2, so a read issued one cycle after a write on the other port returns the new data.
- R3: When port A writes, its own read result for that command is the data just written.
- R4: When port B writes, its own read result for that command is the word stored at that address before the write.
- R5: When one port writes an address that the other port reads in the same command cycle, the reading port returns the old contents.
- R6: A stored codeword with exactly one flipped bit, at any position 0..12, reads back corrected, with the single flag at 1 and the double flag at 0.
- R7: A stored codeword with two flipped bits reads back with the double flag at 1 and the single flag at 0. The two flags are never high together.
- R8: Both ports may write different addresses in the same cycle, and both writes take effect. Writing the same address from both ports in one cycle is not allowed and is flagged by an assertion.
- R9: A synchronous active-low reset drives both ports' data and flags to 0. It does not clear the stored words.
- R10: When the debug flip enable is high at a clock edge, the mask is XORed into the stored codeword at the debug address. Applying the same mask twice restores the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline registers |
| a_addr | input | 4 | Port A word address |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | 8 | Port A write data |
| a_rdata | output | 8 | Port A decoded read data |
| a_sec | output | 1 | Port A single-bit error corrected |
| a_ded | output | 1 | Port A uncorrectable double-bit error |
| b_addr | input | 4 | Port B word address |
| b_we | input | 1 | Port B write enable |
| b_wdata | input | 8 | Port B write data |
| b_rdata | output | 8 | Port B decoded read data |
| b_sec | output | 1 | Port B single-bit error corrected |
| b_ded | output | 1 | Port B uncorrectable double-bit error |
| dbg_flip_en | input | 1 | Debug: apply the flip mask at this edge |
| dbg_flip_addr | input | 4 | Debug: word to corrupt |
| dbg_flip_mask | input | 13 | Debug: codeword bits to invert |

## Verification
A table of address and data pairs is written on port A and read back on port B. This separates correct encode and decode from a swapped or dropped data position. Directed cases then put the two ports in the same cycle: a self-write on A, a self-write on B, a cross-port write against a read, and a write followed one cycle later by a read. These cases tell the per-port read-during-write rules apart and pin the exact pipeline depth. Single flips at the parity bit, a check bit, a data bit and the top position, together with a double flip, tell correction apart from detection. A reset in mid-run shows that the outputs clear while the stored words survive.

// File: rtl/ecc_dpram_pkg.sv
package ecc_dpram_pkg;

  // Read-during-write result a port returns for its own write.
  typedef enum logic {
    RDW_NEW_DATA = 1'b0,
    RDW_OLD_DATA = 1'b1
  } rdw_mode_e;

  // Number of Hamming check bits needed for a given data width.
  function automatic int check_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 8,
  localparam int PB = ecc_dpram_pkg::check_bits(DATA_W),
  localparam int CW = DATA_W + PB + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  output logic [CW-1:0]     code_o
);

  function automatic logic [CW-1:0] build(input logic [DATA_W-1:0] d);
    logic [CW-1:0] c;
    logic          par;
    int            k;
    c = '0;
    k = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos] = d[k];
        k++;
      end
    end
    for (int p = 0; p < PB; p++) begin
      par = 1'b0;
      for (int pos = 1; pos < CW; pos++)
        if (((pos >> p) & 1) == 1) par = par ^ c[pos];
      c[1 << p] = par;
    end
    c[0] = ^c;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) code_o <= '0;
    else        code_o <= build(data_i);
  end

  // R1: every codeword leaving the encoder has even overall parity
  p_even_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (^code_o) == 1'b0);

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 8,
  localparam int PB = ecc_dpram_pkg::check_bits(DATA_W),
  localparam int CW = DATA_W + PB + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);

  int                syn;
  int                k;
  logic              ovr;
  logic [CW-1:0]     fixed;
  logic [DATA_W-1:0] d_c;
  logic              sec_c;
  logic              ded_c;

  always_comb begin
    syn = 0;
    for (int pos = 1; pos < CW; pos++)
      if (code_i[pos]) syn = syn ^ pos;
    ovr   = ^code_i;
    fixed = code_i;
    sec_c = 1'b0;
    ded_c = 1'b0;
    if (ovr) begin
      if (syn < CW) begin
        fixed[syn] = ~fixed[syn];
        sec_c      = 1'b1;
      end else begin
        ded_c = 1'b1;
      end
    end else if (syn != 0) begin
      ded_c = 1'b1;
    end
    k   = 0;
    d_c = '0;
    for (int pos = 1; pos < CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        d_c[k] = fixed[pos];
        k++;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
      sec_o  <= 1'b0;
      ded_o  <= 1'b0;
    end else begin
      data_o <= d_c;
      sec_o  <= sec_c;
      ded_o  <= ded_c;
    end
  end

  // R7: corrected and uncorrectable are mutually exclusive
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_o && ded_o));

endmodule

// File: rtl/dp_code_array.sv
module dp_code_array #(
  parameter int CW    = 13,
  parameter int DEPTH = 16,
  parameter ecc_dpram_pkg::rdw_mode_e RDW_A = ecc_dpram_pkg::RDW_NEW_DATA,
  parameter ecc_dpram_pkg::rdw_mode_e RDW_B = ecc_dpram_pkg::RDW_OLD_DATA,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           we_i,
  input  logic [1:0][AW-1:0]   addr_i,
  input  logic [1:0][CW-1:0]   wd_i,
  output logic [1:0][CW-1:0]   rd_o,
  input  logic                 flip_en_i,
  input  logic [AW-1:0]        flip_addr_i,
  input  logic [CW-1:0]        flip_mask_i
);

  localparam ecc_dpram_pkg::rdw_mode_e MODE [2] = '{RDW_A, RDW_B};

  logic [CW-1:0]           mem [DEPTH];
  logic [1:0]              we_q;
  logic [1:0][AW-1:0]      addr_q;
  logic [1:0][CW-1:0]      wd_q;

  // Registered write-side inputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      we_q   <= we_i;
      addr_q <= addr_i;
      wd_q   <= wd_i;
    end
  end

  // Storage: port A write wins over B, any write wins over debug flip
  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (we_q[0] && addr_q[0] == AW'(w))
        mem[w] <= wd_q[0];
      else if (we_q[1] && addr_q[1] == AW'(w))
        mem[w] <= wd_q[1];
      else if (flip_en_i && flip_addr_i == AW'(w))
        mem[w] <= mem[w] ^ flip_mask_i;
    end
  end

  // Registered read per port; the mode picks the self read-during-write result
  for (genvar p = 0; p < 2; p++) begin : g_port
    if (MODE[p] == ecc_dpram_pkg::RDW_NEW_DATA) begin : g_new
      always_ff @(posedge clk) begin
        if (!rst_n)       rd_o[p] <= '0;
        else if (we_q[p]) rd_o[p] <= wd_q[p];
        else              rd_o[p] <= mem[addr_q[p]];
      end

      // R3: a self-writing new-data port returns what it wrote
      p_self_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_q[p] |=> rd_o[p] == $past(wd_q[p]));
    end else begin : g_old
      always_ff @(posedge clk) begin
        if (!rst_n) rd_o[p] <= '0;
        else        rd_o[p] <= mem[addr_q[p]];
      end
    end
  end

  // R8: both ports writing one word in one cycle is forbidden
  p_write_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_q[0] && we_q[1] && addr_q[0] == addr_q[1]));

endmodule

// File: rtl/ecc_dpram.sv
module ecc_dpram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = DATA_W + ecc_dpram_pkg::check_bits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_sec,
  output logic              a_ded,
  input  logic [AW-1:0]     b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_sec,
  output logic              b_ded,
  input  logic              dbg_flip_en,
  input  logic [AW-1:0]     dbg_flip_addr,
  input  logic [CW-1:0]     dbg_flip_mask
);

  logic [1:0]              we_in;
  logic [1:0][AW-1:0]      addr_in;
  logic [1:0][DATA_W-1:0]  wdata_in;
  logic [1:0]              we_s1;
  logic [1:0][AW-1:0]      addr_s1;
  logic [1:0][CW-1:0]      code_s1;
  logic [1:0][CW-1:0]      code_rd;
  logic [1:0][DATA_W-1:0]  rdata_out;
  logic [1:0]              sec_out;
  logic [1:0]              ded_out;

  assign we_in    = {b_we, a_we};
  assign addr_in  = {b_addr, a_addr};
  assign wdata_in = {b_wdata, a_wdata};

  // Control travels beside the encoder stage so it meets its codeword
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_s1   <= '0;
      addr_s1 <= '0;
    end else begin
      we_s1   <= we_in;
      addr_s1 <= addr_in;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_path
    secded_enc #(.DATA_W(DATA_W)) u_enc (
      .clk    (clk),
      .rst_n  (rst_n),
      .data_i (wdata_in[p]),
      .code_o (code_s1[p])
    );
    secded_dec #(.DATA_W(DATA_W)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (code_rd[p]),
      .data_o (rdata_out[p]),
      .sec_o  (sec_out[p]),
      .ded_o  (ded_out[p])
    );
  end

  dp_code_array #(
    .CW    (CW),
    .DEPTH (DEPTH),
    .RDW_A (ecc_dpram_pkg::RDW_NEW_DATA),
    .RDW_B (ecc_dpram_pkg::RDW_OLD_DATA)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (we_s1),
    .addr_i      (addr_s1),
    .wd_i        (code_s1),
    .rd_o        (code_rd),
    .flip_en_i   (dbg_flip_en),
    .flip_addr_i (dbg_flip_addr),
    .flip_mask_i (dbg_flip_mask)
  );

  assign a_rdata = rdata_out[0];
  assign a_sec   = sec_out[0];
  assign a_ded   = ded_out[0];
  assign b_rdata = rdata_out[1];
  assign b_sec   = sec_out[1];
  assign b_ded   = ded_out[1];

endmodule

// File: tb/ecc_dpram_test.sv
module ecc_dpram_test;

  localparam int PERIOD = 10;
  localparam int NVEC   = 8;
  // {address, data} pairs written on A and read back on B
  localparam logic [11:0] VEC [NVEC] = '{
    12'h0_00, 12'h1_FF, 12'h2_A5, 12'h7_5A,
    12'h8_01, 12'hC_80, 12'hE_3C, 12'hF_C3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  a_addr = '0, b_addr = '0, dbg_flip_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0, dbg_flip_en = 1'b0;
  logic [7:0]  a_wdata = '0, b_wdata = '0;
  logic [12:0] dbg_flip_mask = '0;
  logic [7:0]  a_rdata, b_rdata;
  logic        a_sec, a_ded, b_sec, b_ded;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] shadow [16];

  always #(PERIOD / 2) clk = ~clk;

  ecc_dpram uut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_sec(a_sec), .a_ded(a_ded),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_sec(b_sec), .b_ded(b_ded),
    .dbg_flip_en(dbg_flip_en), .dbg_flip_addr(dbg_flip_addr),
    .dbg_flip_mask(dbg_flip_mask)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one command on each port, then wait until its result is out.
  task automatic txn(input logic awe, input logic [3:0] aad, input logic [7:0] ad,
                     input logic bwe, input logic [3:0] bad, input logic [7:0] bd);
    a_we = awe; a_addr = aad; a_wdata = ad;
    b_we = bwe; b_addr = bad; b_wdata = bd;
    step();
    a_we = 1'b0; b_we = 1'b0;
    step(); step(); step();
  endtask

  task automatic flip(input logic [3:0] ad, input logic [12:0] mask);
    dbg_flip_en = 1'b1; dbg_flip_addr = ad; dbg_flip_mask = mask;
    step();
    dbg_flip_en = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    // R9: outputs cleared during reset
    check("R9 a_rdata in reset", a_rdata, 0);
    check("R9 flags in reset", {a_sec, a_ded, b_sec, b_ded}, 0);
    rst_n = 1'b1;
    step();

    // Table walk - R1: write on A, read on B
    for (int i = 0; i < NVEC; i++) begin
      txn(1'b1, VEC[i][11:8], VEC[i][7:0], 1'b0, 4'h0, 8'h00);
      shadow[VEC[i][11:8]] = VEC[i][7:0];
    end
    for (int i = 0; i < NVEC; i++) begin
      txn(1'b0, 4'h0, 8'h00, 1'b0, VEC[i][11:8], 8'h00);
      check("R1 table readback", b_rdata, VEC[i][7:0]);
      check("R1 table flags", {b_sec, b_ded}, 0);
    end

    // R3 + R5: A writes 3 while B reads 3
    txn(1'b1, 4'h3, 8'h5A, 1'b0, 4'h3, 8'h00);
    shadow[3] = 8'h5A;
    check("R3 port A self write", a_rdata, 8'h5A);
    txn(1'b1, 4'h3, 8'h66, 1'b0, 4'h3, 8'h00);
    check("R5 B sees old on cross write", b_rdata, 8'h5A);
    check("R3 port A self write again", a_rdata, 8'h66);
    shadow[3] = 8'h66;

    // R4: B writes 3, its own result is the old word
    txn(1'b0, 4'h7, 8'h00, 1'b1, 4'h3, 8'hC3);
    check("R4 port B self write old", b_rdata, 8'h66);
    shadow[3] = 8'hC3;
    // R5: B writes 7 while A reads 7
    txn(1'b0, 4'h7, 8'h00, 1'b1, 4'h7, 8'h99);
    check("R5 A sees old on cross write", a_rdata, 8'h5A);
    shadow[7] = 8'h99;
    txn(1'b0, 4'h3, 8'h00, 1'b0, 4'h7, 8'h00);
    check("R4 B write landed", a_rdata, 8'hC3);
    check("R4 B write landed at 7", b_rdata, 8'h99);

    // R2: write on A, same-cycle read on B (old), next-cycle read (new)
    a_we = 1'b1; a_addr = 4'h6; a_wdata = 8'h77;
    b_we = 1'b0; b_addr = 4'h6;
    step();
    a_we = 1'b0;
    step(); step(); step();
    check("R2 same-cycle cross read old", b_rdata, 8'h00);
    step();
    check("R2 next-cycle cross read new", b_rdata, 8'h77);
    shadow[6] = 8'h77;

    // R8: simultaneous writes to distinct addresses both land
    txn(1'b1, 4'h9, 8'h12, 1'b1, 4'hA, 8'h34);
    txn(1'b0, 4'hA, 8'h00, 1'b0, 4'h9, 8'h00);
    check("R8 A write landed", b_rdata, 8'h12);
    check("R8 B write landed", a_rdata, 8'h34);

    // R6: single flips; positions per R1 layout
    txn(1'b1, 4'h5, 8'hB6, 1'b0, 4'h5, 8'h00);
    foreach (VEC[i]) begin end
    flip(4'h5, 13'h0001);
    txn(1'b0, 4'h5, 8'h00, 1'b0, 4'h5, 8'h00);
    check("R6 overall parity bit data", a_rdata, 8'hB6);
    check("R6 overall parity bit flags", {a_sec, a_ded}, 2'b10);
    flip(4'h5, 13'h0001);
    flip(4'h5, 13'h0004);
    txn(1'b0, 4'h5, 8'h00, 1'b0, 4'h5, 8'h00);
    check("R6 check bit data", b_rdata, 8'hB6);
    check("R6 check bit flags", {b_sec, b_ded}, 2'b10);
    flip(4'h5, 13'h0004);
    flip(4'h5, 13'h1000);
    txn(1'b0, 4'h5, 8'h00, 1'b0, 4'h5, 8'h00);
    check("R6 top data bit data", a_rdata, 8'hB6);
    check("R6 top data bit flags", {a_sec, a_ded}, 2'b10);
    flip(4'h5, 13'h1000);
    flip(4'h5, 13'h0008);
    txn(1'b0, 4'h5, 8'h00, 1'b0, 4'h5, 8'h00);
    check("R6 data bit 0 data", b_rdata, 8'hB6);
    check("R6 data bit 0 flags", {b_sec, b_ded}, 2'b10);
    flip(4'h5, 13'h0008);

    // R10: the double application above restored the word
    txn(1'b0, 4'h5, 8'h00, 1'b0, 4'h5, 8'h00);
    check("R10 restored data", a_rdata, 8'hB6);
    check("R10 restored flags", {a_sec, a_ded, b_sec, b_ded}, 0);

    // R7: double flip detected on both ports
    flip(4'h5, 13'h0028);
    txn(1'b0, 4'h5, 8'h00, 1'b0, 4'h5, 8'h00);
    check("R7 double flags A", {a_sec, a_ded}, 2'b01);
    check("R7 double flags B", {b_sec, b_ded}, 2'b01);
    // R1: a fresh write clears the corruption
    txn(1'b1, 4'h5, 8'h4D, 1'b0, 4'h0, 8'h00);
    txn(1'b0, 4'h0, 8'h00, 1'b0, 4'h5, 8'h00);
    check("R1 rewrite after corruption", b_rdata, 8'h4D);
    check("R1 rewrite flags", {b_sec, b_ded}, 0);

    // R9: mid-run reset clears outputs but keeps the words
    rst_n = 1'b0;
    step(); step();
    check("R9 outputs cleared mid-run", {a_rdata, b_rdata}, 0);
    rst_n = 1'b1;
    step();
    txn(1'b0, 4'h6, 8'h00, 1'b0, 4'hF, 8'h00);
    check("R9 word kept at 6", a_rdata, shadow[6]);
    check("R9 word kept at F", b_rdata, shadow[15]);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule